// File: doc/BRIEF.md
# AXI4 Burst Memory Slave with Write-Protected Low Window

This block is an AXI4 slave that stands in for system memory. It has 32-bit addresses, 32-bit data with a 4-bit byte strobe, 8-bit IDs and 8-bit burst lengths. Three bounded queues hold incoming requests: one for read addresses, one for write addresses and one for write data beats. While a queue is full, its ready output is low. Read bursts are served in order from the head of the read-address queue. Write bursts are served in order by pairing the head write address with the queued data beats. Only incrementing 4-byte transfers are modelled, and every response is OKAY.

The lowest `PROT_WORDS` words form a read-only window, for example a boot image. The bus cannot change this window. It can only be filled through a separate preload port, which writes whole words anywhere in the memory. Bus writes that land in the window, or beyond `MEM_WORDS`, are dropped silently, and the burst still completes. Reads beyond the memory depth return zero. The depth and the protected boundary are parameters counted in words, so a test can run a small instance.

Top module: `axi_burst_mem`

## Requirements
- R1: Each of the three queues accepts at most `QUEUE_DEPTH` (default 8) entries. `awready`, `wready` and `arready` are high exactly while the matching queue holds fewer than that. An entry in service still counts as held.
- R2: Read bursts are answered in arrival order. Every beat carries the ID of its request. `rlast` is high on beat `arlen`+1 (counting from 1) and on no other beat.
- R3: Beat k of a read burst returns the word at byte address `araddr`+4k. A word whose index is `MEM_WORDS` or higher reads as 32'h0.
- R4: Within a stored word, bit b of `wstrb` enables byte lane b (bits 8b+7..8b). Lanes whose strobe bit is 0 keep their previous contents.
- R5: A write beat whose word index is below `PROT_WORDS`, or at `MEM_WORDS` or above, leaves memory unchanged. Such a burst still produces its B response.
- R6: `bvalid` rises only after the beat with `wlast` has been taken, with `bid` equal to the write address ID. B responses follow the order of the write addresses. `bresp` and `rresp` are always 2'b00.
- R7: A write data beat is consumed only while a write address is queued. Without one, beats wait in the data queue and no B response appears.
- R8: While `rvalid` is high and `rready` is low, `rvalid`, `rdata`, `rid` and `rlast` hold their values. The same holds for `bvalid` and `bid` while `bready` is low.
- R9: Synchronous active-high `rst` empties all queues. After it, `rvalid` and `bvalid` are low and all three ready outputs are high.
- R10: A cycle with `pl_we` high writes the full word `pl_data` at word index `pl_idx`, including words inside the protected window. It takes priority over a bus write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pl_we | input | 1 | Preload write enable |
| pl_idx | input | IDX_W | Preload word index |
| pl_data | input | 32 | Preload word |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address queue not full |
| awid | input | 8 | Write burst ID |
| awaddr | input | 32 | Write burst start byte address |
| awlen | input | 8 | Write burst beats minus one |
| awsize | input | 3 | Transfer size, expected 3'd2 |
| awburst | input | 2 | Burst type, expected INCR (2'b01) |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data queue not full |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte lane enables |
| wlast | input | 1 | Last beat of write burst |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response accepted |
| bid | output | 8 | Write response ID |
| bresp | output | 2 | Write response code, always OKAY |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address queue not full |
| arid | input | 8 | Read burst ID |
| araddr | input | 32 | Read burst start byte address |
| arlen | input | 8 | Read burst beats minus one |
| arsize | input | 3 | Transfer size, expected 3'd2 |
| arburst | input | 2 | Burst type, expected INCR (2'b01) |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data accepted |
| rid | output | 8 | Read data ID |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code, always OKAY |
| rlast | output | 1 | Last beat of read burst |

## Verification
The hardest state to reach from the ports is a full queue standing behind a burst that is parked in service. Reaching it needs the responder to stall while more requests keep arriving. For reads, the bench holds `rready` low and offers nine read addresses, so the first one sits presented on R while the queue fills. For writes, it holds `bready` low and sends data beats before any write address exists. It then sends addresses until the first B response is stuck and both write queues are full. Only after the ready outputs have been seen low does it release the stall and drain the queues, checking the ID order and the stored words.

// File: rtl/axi_burst_mem_pkg.sv
package axi_burst_mem_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int ID_W   = 8;
  localparam int LEN_W  = 8;
  localparam int STRB_W = DATA_W / 8;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
  } addr_req_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [STRB_W-1:0] strb;
    logic              last;
  } wbeat_t;

  localparam int REQ_W  = $bits(addr_req_t);
  localparam int BEAT_W = $bits(wbeat_t);

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/axi_burst_mem_fifo.sv
module axi_burst_mem_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R7
endmodule

// File: rtl/axi_burst_mem_store.sv
module axi_burst_mem_store #(
  parameter int WORDS  = 1024,
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ram [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BE_W; b++) begin
        if (be[b]) ram[widx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
    if (re) rdata <= ram[ridx];
  end

  AST_WIDX_IN_DEPTH: assert property (@(posedge clk) disable iff (rst)
    we |-> (32'(widx) < WORDS)); // R5
  AST_RIDX_IN_DEPTH: assert property (@(posedge clk) disable iff (rst)
    re |-> (32'(ridx) < WORDS)); // R3
endmodule

// File: rtl/axi_burst_mem_rd.sv
module axi_burst_mem_rd
  import axi_burst_mem_pkg::*;
#(
  parameter int MEM_WORDS = 1024,
  parameter int IDX_W     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  addr_req_t         head,
  input  logic              q_empty,
  output logic              q_pop,
  output logic              mem_re,
  output logic [IDX_W-1:0]  mem_idx,
  input  logic [DATA_W-1:0] mem_q,
  output logic              rvalid,
  input  logic              rready,
  output logic [ID_W-1:0]   rid,
  output logic [DATA_W-1:0] rdata,
  output logic              rlast
);
  typedef enum logic [1:0] {RS_IDLE, RS_FETCH, RS_LOAD, RS_SEND} rd_state_e;

  rd_state_e         state;
  logic [ADDR_W-1:0] cur_addr, word;
  logic [LEN_W-1:0]  remain;
  logic              in_range;
  logic              rvalid_q, rlast_q;
  logic [ID_W-1:0]   rid_q;
  logic [DATA_W-1:0] rdata_q;

  assign word     = cur_addr >> 2;
  assign in_range = word < ADDR_W'(MEM_WORDS);
  assign mem_re   = (state == RS_FETCH) && in_range;
  assign mem_idx  = word[IDX_W-1:0];
  assign q_pop    = (state == RS_SEND) && rready && rlast_q;

  assign rvalid = rvalid_q;
  assign rid    = rid_q;
  assign rdata  = rdata_q;
  assign rlast  = rlast_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RS_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      rvalid_q <= 1'b0;
      rlast_q  <= 1'b0;
      rid_q    <= '0;
      rdata_q  <= '0;
    end else begin
      case (state)
        RS_IDLE: if (!q_empty) begin
          cur_addr <= head.addr;
          remain   <= head.len;
          rid_q    <= head.id;
          state    <= RS_FETCH;
        end
        RS_FETCH: state <= RS_LOAD;
        RS_LOAD: begin
          rdata_q  <= in_range ? mem_q : '0;
          rlast_q  <= (remain == '0);
          rvalid_q <= 1'b1;
          state    <= RS_SEND;
        end
        RS_SEND: if (rready) begin
          rvalid_q <= 1'b0;
          if (rlast_q) begin
            state <= RS_IDLE;
          end else begin
            cur_addr <= cur_addr + ADDR_W'(4);
            remain   <= remain - 1'b1;
            state    <= RS_FETCH;
          end
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  AST_R_HOLD: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rid) && $stable(rlast)); // R8
  AST_R_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> !q_empty); // R2
endmodule

// File: rtl/axi_burst_mem_wr.sv
module axi_burst_mem_wr
  import axi_burst_mem_pkg::*;
#(
  parameter int MEM_WORDS  = 1024,
  parameter int PROT_WORDS = 256,
  parameter int IDX_W      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  addr_req_t         aw_head,
  input  logic              aw_empty,
  output logic              aw_pop,
  input  wbeat_t            w_head,
  input  logic              w_empty,
  output logic              w_pop,
  input  logic              stall,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [STRB_W-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              bvalid,
  input  logic              bready,
  output logic [ID_W-1:0]   bid
);
  logic [LEN_W-1:0]  beat;
  logic [ADDR_W-1:0] beat_addr, word;
  logic              writable, go, bvalid_q, b_done;
  logic [ID_W-1:0]   bid_q;

  assign beat_addr = aw_head.addr + (ADDR_W'(beat) << 2);
  assign word      = beat_addr >> 2;
  assign writable  = (word >= ADDR_W'(PROT_WORDS)) && (word < ADDR_W'(MEM_WORDS));
  assign go        = !bvalid_q && !aw_empty && !w_empty && !stall;
  assign b_done    = bvalid_q && bready;

  assign mem_we    = go && writable;
  assign mem_idx   = word[IDX_W-1:0];
  assign mem_be    = w_head.strb;
  assign mem_wdata = w_head.data;
  assign w_pop     = (go && !w_head.last) || b_done;
  assign aw_pop    = b_done;

  assign bvalid = bvalid_q;
  assign bid    = bid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat     <= '0;
      bvalid_q <= 1'b0;
      bid_q    <= '0;
    end else begin
      if (go) begin
        if (w_head.last) begin
          bvalid_q <= 1'b1;
          bid_q    <= aw_head.id;
        end else begin
          beat <= beat + 1'b1;
        end
      end
      if (b_done) begin
        bvalid_q <= 1'b0;
        beat     <= '0;
      end
    end
  end

  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid && $stable(bid)); // R8
  AST_B_HAS_ADDR: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> !aw_empty && !w_empty); // R6
  AST_BEAT_IN_LEN: assert property (@(posedge clk) disable iff (rst)
    go |-> beat <= aw_head.len); // R6
endmodule

// File: rtl/axi_burst_mem.sv
module axi_burst_mem
  import axi_burst_mem_pkg::*;
#(
  parameter int MEM_WORDS   = 1024,
  parameter int PROT_WORDS  = 256,
  parameter int QUEUE_DEPTH = 8,
  localparam int IDX_W      = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pl_we,
  input  logic [IDX_W-1:0]  pl_idx,
  input  logic [31:0]       pl_data,
  input  logic              awvalid,
  output logic              awready,
  input  logic [7:0]        awid,
  input  logic [31:0]       awaddr,
  input  logic [7:0]        awlen,
  input  logic [2:0]        awsize,
  input  logic [1:0]        awburst,
  input  logic              wvalid,
  output logic              wready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  input  logic              wlast,
  output logic              bvalid,
  input  logic              bready,
  output logic [7:0]        bid,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  input  logic [7:0]        arid,
  input  logic [31:0]       araddr,
  input  logic [7:0]        arlen,
  input  logic [2:0]        arsize,
  input  logic [1:0]        arburst,
  output logic              rvalid,
  input  logic              rready,
  output logic [7:0]        rid,
  output logic [31:0]       rdata,
  output logic [1:0]        rresp,
  output logic              rlast
);
  addr_req_t         aw_in, ar_in, aw_head, ar_head;
  wbeat_t            w_in, w_head;
  logic [REQ_W-1:0]  aw_head_v, ar_head_v;
  logic [BEAT_W-1:0] w_head_v;
  logic aw_empty, aw_full, aw_pop;
  logic w_empty, w_full, w_pop;
  logic ar_empty, ar_full, ar_pop;

  logic              eng_we, st_we, rd_re;
  logic [IDX_W-1:0]  eng_idx, st_widx, rd_idx;
  logic [STRB_W-1:0] eng_be, st_be;
  logic [DATA_W-1:0] eng_wdata, st_wdata, rd_q;

  assign aw_in = '{id: awid, addr: awaddr, len: awlen};
  assign ar_in = '{id: arid, addr: araddr, len: arlen};
  assign w_in  = '{data: wdata, strb: wstrb, last: wlast};

  assign awready = !aw_full;
  assign wready  = !w_full;
  assign arready = !ar_full;
  assign bresp   = RESP_OKAY;
  assign rresp   = RESP_OKAY;

  axi_burst_mem_fifo #(.WIDTH(REQ_W), .DEPTH(QUEUE_DEPTH)) u_awq (
    .clk(clk), .rst(rst), .push(awvalid && awready), .push_data(aw_in),
    .pop(aw_pop), .head(aw_head_v), .empty(aw_empty), .full(aw_full));

  axi_burst_mem_fifo #(.WIDTH(BEAT_W), .DEPTH(QUEUE_DEPTH)) u_wq (
    .clk(clk), .rst(rst), .push(wvalid && wready), .push_data(w_in),
    .pop(w_pop), .head(w_head_v), .empty(w_empty), .full(w_full));

  axi_burst_mem_fifo #(.WIDTH(REQ_W), .DEPTH(QUEUE_DEPTH)) u_arq (
    .clk(clk), .rst(rst), .push(arvalid && arready), .push_data(ar_in),
    .pop(ar_pop), .head(ar_head_v), .empty(ar_empty), .full(ar_full));

  assign aw_head = addr_req_t'(aw_head_v);
  assign ar_head = addr_req_t'(ar_head_v);
  assign w_head  = wbeat_t'(w_head_v);

  axi_burst_mem_wr #(.MEM_WORDS(MEM_WORDS), .PROT_WORDS(PROT_WORDS), .IDX_W(IDX_W)) u_wr (
    .clk(clk), .rst(rst), .aw_head(aw_head), .aw_empty(aw_empty), .aw_pop(aw_pop),
    .w_head(w_head), .w_empty(w_empty), .w_pop(w_pop), .stall(pl_we),
    .mem_we(eng_we), .mem_idx(eng_idx), .mem_be(eng_be), .mem_wdata(eng_wdata),
    .bvalid(bvalid), .bready(bready), .bid(bid));

  axi_burst_mem_rd #(.MEM_WORDS(MEM_WORDS), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst(rst), .head(ar_head), .q_empty(ar_empty), .q_pop(ar_pop),
    .mem_re(rd_re), .mem_idx(rd_idx), .mem_q(rd_q),
    .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata), .rlast(rlast));

  assign st_we    = pl_we || eng_we;
  assign st_widx  = pl_we ? pl_idx : eng_idx;
  assign st_be    = pl_we ? '1 : eng_be;
  assign st_wdata = pl_we ? pl_data : eng_wdata;

  axi_burst_mem_store #(.WORDS(MEM_WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W), .BE_W(STRB_W)) u_store (
    .clk(clk), .rst(rst), .we(st_we), .widx(st_widx), .be(st_be), .wdata(st_wdata),
    .re(rd_re), .ridx(rd_idx), .rdata(rd_q));

  AST_AW_SHAPE: assert property (@(posedge clk) disable iff (rst)
    awvalid |-> awsize == 3'd2 && awburst == 2'b01 && awaddr[1:0] == 2'b00); // R3
  AST_AR_SHAPE: assert property (@(posedge clk) disable iff (rst)
    arvalid |-> arsize == 3'd2 && arburst == 2'b01 && araddr[1:0] == 2'b00); // R3
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rvalid && !bvalid && awready && wready && arready); // R9
endmodule

// File: tb/axi_burst_mem_tb_top.sv
module axi_burst_mem_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 64;
  localparam int PROT  = 16;
  localparam int QD    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pl_we = 1'b0;
  logic [5:0] pl_idx = '0;
  logic [31:0] pl_data = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic [7:0] awid = '0, awlen = '0, arid = '0, arlen = '0;
  logic [31:0] awaddr = '0, araddr = '0, wdata = '0;
  logic [3:0] wstrb = '0;
  logic wlast = 1'b0;
  logic bready = 1'b1, rready = 1'b1;
  logic awready, wready, arready, bvalid, rvalid, rlast;
  logic [7:0] bid, rid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_burst_mem #(.MEM_WORDS(WORDS), .PROT_WORDS(PROT), .QUEUE_DEPTH(QD)) dut_i (
    .clk(clk), .rst(rst), .pl_we(pl_we), .pl_idx(pl_idx), .pl_data(pl_data),
    .awvalid(awvalid), .awready(awready), .awid(awid), .awaddr(awaddr), .awlen(awlen),
    .awsize(3'd2), .awburst(2'b01),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
    .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr), .arlen(arlen),
    .arsize(3'd2), .arburst(2'b01),
    .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] strb);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (strb[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic try_ar(input logic [7:0] id, input int idx, input int len,
                        input int limit, output bit ok);
    ok = 0; arvalid = 1'b1; arid = id; araddr = 32'(idx) * 4; arlen = 8'(len);
    for (int t = 0; t < limit && !ok; t++) begin
      if (arready) ok = 1;
      @(negedge clk);
    end
    arvalid = 1'b0;
  endtask

  task automatic try_aw(input logic [7:0] id, input int idx, input int len,
                        input int limit, output bit ok);
    ok = 0; awvalid = 1'b1; awid = id; awaddr = 32'(idx) * 4; awlen = 8'(len);
    for (int t = 0; t < limit && !ok; t++) begin
      if (awready) ok = 1;
      @(negedge clk);
    end
    awvalid = 1'b0;
  endtask

  task automatic try_w(input logic [31:0] d, input logic [3:0] s, input bit last,
                       input int limit, output bit ok);
    ok = 0; wvalid = 1'b1; wdata = d; wstrb = s; wlast = last;
    for (int t = 0; t < limit && !ok; t++) begin
      if (wready) ok = 1;
      @(negedge clk);
    end
    wvalid = 1'b0;
  endtask

  task automatic collect_r(input logic [7:0] id, input int idx, input int len, input string req);
    for (int k = 0; k <= len; k++) begin
      int w = 0;
      logic [31:0] exp;
      while (!rvalid && w < 1000) begin @(negedge clk); w++; end
      exp = (idx + k < WORDS) ? model[idx + k] : 32'h0;
      chk(rvalid, req, "rvalid", 32'(rvalid), 32'h1);
      chk(rdata == exp, req, $sformatf("rdata word %0d", idx + k), rdata, exp);
      chk(rid == id, req, "rid", 32'(rid), 32'(id));
      chk(rlast == (k == len), "R2", "rlast", 32'(rlast), 32'(k == len));
      chk(rresp == 2'b00, "R6", "rresp", 32'(rresp), 32'h0);
      @(negedge clk);
    end
  endtask

  task automatic rd_check(input logic [7:0] id, input int idx, input int len, input string req);
    bit ok;
    try_ar(id, idx, len, 1000, ok);
    chk(ok, "R1", "arready", 32'(ok), 32'h1);
    collect_r(id, idx, len, req);
  endtask

  task automatic collect_b(input logic [7:0] id, input string req);
    int w = 0;
    while (!bvalid && w < 1000) begin @(negedge clk); w++; end
    chk(bvalid, req, "bvalid", 32'(bvalid), 32'h1);
    chk(bid == id, "R6", "bid", 32'(bid), 32'(id));
    chk(bresp == 2'b00, "R6", "bresp", 32'(bresp), 32'h0);
    @(negedge clk);
  endtask

  task automatic wr_burst(input logic [7:0] id, input int idx, input int len,
                          input logic [31:0] base, input logic [3:0] strb, input string req);
    bit ok;
    try_aw(id, idx, len, 1000, ok);
    chk(ok, "R1", "awready", 32'(ok), 32'h1);
    for (int k = 0; k <= len; k++) begin
      try_w(base + 32'(k), strb, k == len, 1000, ok);
      chk(ok, "R1", "wready", 32'(ok), 32'h1);
      if (idx + k >= PROT && idx + k < WORDS)
        model[idx + k] = merge(model[idx + k], base + 32'(k), strb);
    end
    collect_b(id, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    int acc;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(awready, "R9", "awready", 32'(awready), 32'h1);
    chk(wready,  "R9", "wready",  32'(wready),  32'h1);
    chk(arready, "R9", "arready", 32'(arready), 32'h1);
    chk(!rvalid, "R9", "rvalid",  32'(rvalid),  32'h0);
    chk(!bvalid, "R9", "bvalid",  32'(bvalid),  32'h0);

    // R10 preload whole memory, then R2/R3 full sweep
    for (int i = 0; i < WORDS; i++) begin
      pl_we = 1'b1; pl_idx = 6'(i); pl_data = 32'h9E3779B9 * 32'(i + 1);
      model[i] = pl_data;
      @(negedge clk);
    end
    pl_we = 1'b0;
    rd_check(8'h11, 0, WORDS - 1, "R10");
    // R3 read crossing the depth returns zero
    rd_check(8'h22, WORDS - 4, 7, "R3");
    // R2 several short bursts of varied length
    for (int n = 0; n < 6; n++) rd_check(8'(8'h30 + n), 7 * n, n, "R2");

    // R4 strobe sweep: one word per strobe value
    for (int s = 0; s < 16; s++)
      wr_burst(8'(8'h50 + s), 20 + s, 0, 32'hC3A50000 + 32'(s * 32'h01110111), 4'(s), "R4");
    rd_check(8'h5F, 20, 15, "R4");

    // R5 burst straddling the protected boundary, and one past the depth
    wr_burst(8'h61, PROT - 4, 7, 32'h0BAD0000, 4'hF, "R5");
    rd_check(8'h62, PROT - 8, 15, "R5");
    wr_burst(8'h63, WORDS - 2, 3, 32'h0FF00000, 4'hF, "R5");
    rd_check(8'h64, WORDS - 8, 7, "R5");

    // R10 preload reaches into the protected window
    pl_we = 1'b1; pl_idx = 6'd5; pl_data = 32'h5A5A1234; model[5] = 32'h5A5A1234;
    @(negedge clk);
    pl_we = 1'b0;
    rd_check(8'h65, 4, 2, "R10");

    // R1/R8: read queue fills behind a stalled beat
    rready = 1'b0;
    acc = 0;
    for (int n = 0; n < QD + 1; n++) begin
      try_ar(8'(8'h40 + n), 16 + n, 0, 4, ok);
      if (ok) acc++;
    end
    chk(acc == QD, "R1", "read addresses accepted", 32'(acc), 32'(QD));
    chk(!arready, "R1", "arready when full", 32'(arready), 32'h0);
    chk(rvalid && rid == 8'h40, "R8", "stalled rid", 32'(rid), 32'h40);
    held = rdata;
    repeat (5) @(negedge clk);
    chk(rvalid, "R8", "rvalid held", 32'(rvalid), 32'h1);
    chk(rdata == held, "R8", "rdata held", rdata, held);
    rready = 1'b1;
    for (int n = 0; n < QD; n++) collect_r(8'(8'h40 + n), 16 + n, 0, "R2");

    // R7/R1: data beats without an address
    bready = 1'b0;
    acc = 0;
    for (int n = 0; n < QD + 1; n++) begin
      try_w(32'h7E570000 + 32'(n), 4'hF, 1'b1, 4, ok);
      if (ok) acc++;
    end
    chk(acc == QD, "R1", "data beats accepted", 32'(acc), 32'(QD));
    chk(!wready, "R1", "wready when full", 32'(wready), 32'h0);
    repeat (4) @(negedge clk);
    chk(!bvalid, "R7", "bvalid without address", 32'(bvalid), 32'h0);
    acc = 0;
    for (int n = 0; n < QD + 1; n++) begin
      try_aw(8'(8'h80 + n), 40 + n, 0, 4, ok);
      if (ok) acc++;
    end
    chk(acc == QD, "R1", "write addresses accepted", 32'(acc), 32'(QD));
    chk(bvalid && bid == 8'h80, "R8", "stalled bid", 32'(bid), 32'h80);
    repeat (3) @(negedge clk);
    chk(bvalid && bid == 8'h80, "R8", "bid held", 32'(bid), 32'h80);
    bready = 1'b1;
    for (int n = 0; n < QD; n++) begin
      model[40 + n] = 32'h7E570000 + 32'(n);
      collect_b(8'(8'h80 + n), "R6");
    end
    rd_check(8'h90, 40, QD - 1, "R7");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule